// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Core

This block is a synthesizable stand-in for an asynchronous static memory with a 16-bit word split into two byte lanes. It is used in simulation and in prototypes where a board-level memory part must be replaced by on-chip logic. A clock samples the memory's control pins. The pins are an active-low select and an active-high select, a write strobe, an output strobe, and one active-low select per byte. From these pins the block works out whether the current cycle is a standby, a read, a write or an output disable.

A tri-state data pin cannot be synthesized, so reads return two things instead: a data-out vector and one output-enable bit per byte lane. A lane whose enable bit is low is understood to be floating, and its data bits are held at zero. A write updates only the lanes whose byte select is low. The external address is 20 bits wide. Only the low log2(DEPTH) bits select a word, and DEPTH must be a power of two (default 1024).

Top module: `bytelane_sram_core`

## Requirements
- R1: When `cs_a_n` is high or `cs_b` is low, the block is deselected. On the next clock, `lane_oe` is 2'b00, and no stored byte changes, whatever the other inputs are.
- R2: When the chip is selected and both `lo_sel_n` and `hi_sel_n` are high, the block is in standby. On the next clock `lane_oe` is 2'b00, and even with `wr_n` low no byte is written.
- R3: A read is a cycle in which the chip is selected, `wr_n` is high, `oe_n` is low and at least one byte select is low. After the next clock, `lane_oe[0]` equals the inverse of `lo_sel_n` (lane 0 is bits 7:0). `lane_oe[1]` equals the inverse of `hi_sel_n` (lane 1 is bits 15:8). Each enabled lane of `dout` carries the stored byte.
- R4: When the chip is selected and both `wr_n` and `oe_n` are high, the outputs are disabled. `lane_oe` is 2'b00 after the next clock.
- R5: A write is a cycle in which the chip is selected, `wr_n` is low and at least one byte select is low. On that clock edge, only the lanes whose select is low take `din`, and the other lane keeps its previous contents.
- R6: `wr_n` low takes priority over `oe_n`. After any cycle with `wr_n` low, `lane_oe` is 2'b00, even when `oe_n` is low.
- R7: While a lane's bit of `lane_oe` is low, that lane's eight bits of `dout` are zero.
- R8: Address bits at or above log2(DEPTH) are ignored. Two addresses that differ only in those bits reach the same word.
- R9: While `rst_n` is low and on the first cycle after reset, `lane_oe` is 2'b00 and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| cs_a_n | input | 1 | Active-low chip select |
| cs_b | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| lo_sel_n | input | 1 | Active-low select for byte lane 0 (bits 7:0) |
| hi_sel_n | input | 1 | Active-low select for byte lane 1 (bits 15:8) |
| addr | input | 20 | Word address; only the low log2(DEPTH) bits are used |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data, zero on lanes that are not driven |
| lane_oe | output | 2 | Registered per-lane drive enable; bit 0 is lane 0 |

## Verification
The assertions are checked on every cycle. They cover the float rules for deselect, empty byte selects, output disable and write priority. They also check the exact per-lane enable pattern after a read, zero data on floating lanes, and that the decoder never issues a write mask without both selects and the write strobe active. Some behaviour only the bench scenarios can show. This includes that a write changes the selected lane and keeps the other, that blocked writes leave memory unchanged, and that aliased addresses reach the same word. Each of these is shown by writing through one path and reading back through another.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_HIZ   = 2'd3
  } bls_op_e;

  // Operation chosen by the pin levels; deselect and empty lane set win first,
  // then the write strobe, then the output strobe.
  function automatic bls_op_e pick_op(input logic cs_a_n, input logic cs_b,
                                      input logic wr_n, input logic oe_n,
                                      input logic lo_n, input logic hi_n);
    if (cs_a_n || !cs_b)  return OP_IDLE;
    if (lo_n && hi_n)     return OP_IDLE;
    if (!wr_n)            return OP_WRITE;
    if (!oe_n)            return OP_READ;
    return OP_HIZ;
  endfunction

  // Lane activity vector: bit 0 is the low byte.
  function automatic logic [1:0] lanes_of(input logic lo_n, input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic             lo_sel_n,
  input  logic             hi_sel_n,
  output bls_op_e          op,
  output logic [LANES-1:0] wmask,
  output logic [LANES-1:0] rmask
);

  logic [LANES-1:0] active;

  always_comb begin
    op     = pick_op(cs_a_n, cs_b, wr_n, oe_n, lo_sel_n, hi_sel_n);
    active = lanes_of(lo_sel_n, hi_sel_n);
    wmask  = (op == OP_WRITE) ? active : '0;
    rmask  = (op == OP_READ)  ? active : '0;
  end

endmodule

// File: rtl/bls_store.sv
module bls_store #(
  parameter int DEPTH = 1024,
  parameter int LANES = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW    = LANES * 8
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] wmask,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bytes [DEPTH];

    always_ff @(posedge clk) begin
      if (wmask[g]) bytes[idx] <= wdata[g*8 +: 8];
    end

    assign rdata[g*8 +: 8] = bytes[idx];
  end

endmodule

// File: rtl/bls_rdport.sv
module bls_rdport #(
  parameter int LANES = 2,
  localparam int DW = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] rmask,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    dout,
  output logic [LANES-1:0] lane_oe
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_oe[g]      <= 1'b0;
        dout[g*8 +: 8]  <= 8'h00;
      end else begin
        lane_oe[g]      <= rmask[g];
        dout[g*8 +: 8]  <= rmask[g] ? rdata[g*8 +: 8] : 8'h00;
      end
    end
  end

endmodule

// File: rtl/bytelane_sram_core.sv
module bytelane_sram_core
  import bls_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              lo_sel_n,
  input  logic              hi_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        lane_oe
);

  localparam int LANES = 2;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  bls_op_e          op;
  logic [LANES-1:0] wmask;
  logic [LANES-1:0] rmask;
  logic [15:0]      rdata;
  logic [IDX_W-1:0] idx;

  assign idx = addr[IDX_W-1:0];

  if (ADDR_W > IDX_W) begin : g_alias
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:IDX_W];
  end

  bls_decode #(.LANES(LANES)) u_dec (
    .cs_a_n  (cs_a_n),
    .cs_b    (cs_b),
    .wr_n    (wr_n),
    .oe_n    (oe_n),
    .lo_sel_n(lo_sel_n),
    .hi_sel_n(hi_sel_n),
    .op      (op),
    .wmask   (wmask),
    .rmask   (rmask)
  );

  bls_store #(.DEPTH(DEPTH), .LANES(LANES)) u_mem (
    .clk  (clk),
    .idx  (idx),
    .wmask(wmask),
    .wdata(din),
    .rdata(rdata)
  );

  bls_rdport #(.LANES(LANES)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rmask  (rmask),
    .rdata  (rdata),
    .dout   (dout),
    .lane_oe(lane_oe)
  );

endmodule

// File: rtl/bls_checker.sv
module bls_checker
  import bls_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cs_a_n,
  input logic        cs_b,
  input logic        wr_n,
  input logic        oe_n,
  input logic        lo_sel_n,
  input logic        hi_sel_n,
  input logic [15:0] dout,
  input logic [1:0]  lane_oe,
  input logic [1:0]  wmask
);

  logic sel;
  assign sel = !cs_a_n && cs_b;

  p_deselect_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> lane_oe == 2'b00);

  p_nolane_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && lo_sel_n && hi_sel_n) |=> lane_oe == 2'b00);

  p_read_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_n && !oe_n) |=> lane_oe == {~$past(hi_sel_n), ~$past(lo_sel_n)});

  p_outdis_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_n && oe_n) |=> lane_oe == 2'b00);

  p_write_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask != 2'b00) |-> (sel && !wr_n));

  p_write_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> lane_oe == 2'b00);

  p_dead_lane_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_oe[0] |-> dout[7:0] == 8'h00) and (!lane_oe[1] |-> dout[15:8] == 8'h00));

endmodule

bind bytelane_sram_core bls_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_a_n  (cs_a_n),
  .cs_b    (cs_b),
  .wr_n    (wr_n),
  .oe_n    (oe_n),
  .lo_sel_n(lo_sel_n),
  .hi_sel_n(hi_sel_n),
  .dout    (dout),
  .lane_oe (lane_oe),
  .wmask   (wmask)
);

// File: tb/bytelane_sram_core_test.sv
module bytelane_sram_core_test;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_a_n = 1'b1, cs_b = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
  logic        lo_sel_n = 1'b1, hi_sel_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  lane_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [15:0] ref_mem [int];

  always #5ns clk = ~clk;

  bytelane_sram_core #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .wr_n(wr_n), .oe_n(oe_n), .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n),
    .addr(addr), .din(din), .dout(dout), .lane_oe(lane_oe)
  );

  task automatic check(string req, logic [1:0] e_oe, logic [15:0] e_do);
    n_tests++;
    if (lane_oe !== e_oe || dout !== e_do) begin
      n_fail++;
      $display("FAIL %s: lane_oe=%b dout=%h expected lane_oe=%b dout=%h",
               req, lane_oe, dout, e_oe, e_do);
    end
  endtask

  // One sampled cycle: drive at negedge, model predicts, compare at next negedge.
  task automatic cycle(string req, bit c1n, bit c2, bit wn, bit on, bit ln, bit hn,
                       logic [19:0] a, logic [15:0] d);
    int key;
    bit sel;
    logic [1:0]  e_oe;
    logic [15:0] e_do;
    logic [15:0] word;
    cs_a_n = c1n; cs_b = c2; wr_n = wn; oe_n = on;
    lo_sel_n = ln; hi_sel_n = hn; addr = a; din = d;
    key  = int'(a) % DEPTH;
    sel  = !c1n && c2 && !(ln && hn);
    word = ref_mem.exists(key) ? ref_mem[key] : 16'h0000;
    e_oe = 2'b00;
    e_do = 16'h0000;
    if (sel && !wn) begin
      if (!ln) word[7:0]  = d[7:0];
      if (!hn) word[15:8] = d[15:8];
      ref_mem[key] = word;
    end else if (sel && !on) begin
      e_oe = {!hn, !ln};
      if (!ln) e_do[7:0]  = word[7:0];
      if (!hn) e_do[15:8] = word[15:8];
    end
    @(posedge clk);
    @(negedge clk);
    check(req, e_oe, e_do);
  endtask

  initial begin
    #2ms;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 during reset", 2'b00, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", 2'b00, 16'h0000);

    // R5/R6: full write with output strobe low still floats
    cycle("R6 write floats", 0, 1, 0, 0, 0, 0, 20'h00010, 16'hA1B2);
    cycle("R3 full read",    0, 1, 1, 0, 0, 0, 20'h00010, 16'h0000);
    // R5: lower-only write keeps upper
    cycle("R5 low write",    0, 1, 0, 1, 0, 1, 20'h00010, 16'hFFC3);
    cycle("R5 readback",     0, 1, 1, 0, 0, 0, 20'h00010, 16'h0000);
    // R3/R7: single-lane reads
    cycle("R7 low lane read",  0, 1, 1, 0, 0, 1, 20'h00010, 16'h0000);
    cycle("R7 high lane read", 0, 1, 1, 0, 1, 0, 20'h00010, 16'h0000);
    // R5: upper-only write at top address, after full write
    cycle("R5 full write top", 0, 1, 0, 1, 0, 0, 20'h003FF, 16'h1234);
    cycle("R5 high write top", 0, 1, 0, 1, 1, 0, 20'h003FF, 16'hEE99);
    cycle("R5 top readback",   0, 1, 1, 0, 0, 0, 20'h003FF, 16'h0000);
    // R2: no byte selected, write blocked
    cycle("R2 empty lanes",  0, 1, 0, 0, 1, 1, 20'h00010, 16'h5555);
    cycle("R2 readback",     0, 1, 1, 0, 0, 0, 20'h00010, 16'h0000);
    // R1: deselect by either pin, write blocked
    cycle("R1 cs_a_n high",  1, 1, 0, 0, 0, 0, 20'h00010, 16'h6666);
    cycle("R1 cs_b low",     0, 0, 0, 0, 0, 0, 20'h00010, 16'h7777);
    cycle("R1 read while deselected", 1, 0, 1, 0, 0, 0, 20'h00010, 16'h0000);
    cycle("R1 readback",     0, 1, 1, 0, 0, 0, 20'h00010, 16'h0000);
    // R4: output disable
    cycle("R4 output disable", 0, 1, 1, 1, 0, 0, 20'h00010, 16'h0000);
    // R8: aliasing through ignored upper bits
    cycle("R8 alias read",   0, 1, 1, 0, 0, 0, 20'hFF010, 16'h0000);
    cycle("R8 alias write",  0, 1, 0, 1, 0, 0, 20'h40020, 16'h0BAD);
    cycle("R8 base read",    0, 1, 1, 0, 0, 0, 20'h00020, 16'h0000);
    // back-to-back reads of distinct words
    for (int i = 0; i < 8; i++)
      cycle("R5 pattern write", 0, 1, 0, 1, 0, 0, 20'(100 + i), 16'(i * 16'h1357));
    for (int i = 0; i < 8; i++)
      cycle("R3 pattern read", 0, 1, 1, 0, i[0], !i[0], 20'(100 + i), 16'h0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule